// File: doc/BRIEF.md
# High-Resolution Edge Timestamp Capture

This block timestamps edges on a bank of input pins. A single time base runs on the fast clock. Its low seven bits form the fine offset inside a loop period of 128 fast clocks, and the upper 25 bits count whole loop periods. Each channel synchronises its pin, qualifies edges by its configured polarity, and holds the first qualifying edge of the current loop. At the end of the loop that edge is published to the channel's capture register with the full 32-bit stamp, so the result has fast-clock resolution while results appear once per loop.

Neighbouring channels can be paired: channel 2p is the even member and channel 2p+1 the odd member. When a pair is joined, the odd channel's capture structure listens to the even pin instead of its own. It records the next qualifying edge of the even pin that the even channel did not take, so one loop can yield both a rising and a falling time for one signal. The odd pin stays readable as a plain synchronised level.

Top module: `hr_edge_capture`

## Requirements
- R1: While reset is asserted and right after it, every capture word, valid flag and overrun flag reads zero.
- R2: A stamp is the time-base value {loop count in bits 31:7, fine offset in bits 6:0}, counting fast clocks since reset release. An edge is stamped with the value two clocks after the first rising clock edge that samples the new pin level, because the pin passes a two-flop synchroniser.
- R3: Each channel c has a 2-bit select at mode bits [2c+1:2c]: 0 captures nothing, 1 rising edges, 2 falling edges, 3 both.
- R4: On the clock edge where the fine offset wraps from 127 to 0, a channel that saw a qualifying edge in the ending loop loads that edge's stamp into its capture word.
- R5: Only the first qualifying edge of a loop is kept per channel. Later edges in the same loop do not change the published stamp.
- R6: An edge detected in the last cycle of a loop is published at that same wrap with fine offset 127. It is never replaced by an older stamp.
- R7: A publish sets the valid flag. A read strobe clears valid and overrun. When a read and a publish fall on the same clock, valid ends set and overrun clear.
- R8: A publish while valid is still set and no read is present sets the overrun flag. The capture word then holds the newer stamp.
- R9: With share bit p set, odd channel 2p+1 takes edges from pin 2p. It records the first edge qualified by its own select that channel 2p did not take in that loop. Edges on pin 2p+1 produce no capture.
- R10: The level output carries the synchronised state of every pin, including an odd pin whose pair is joined.
- R11: A loop with no qualifying edge leaves the capture word and the valid flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the time base and capture logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_CH | Raw pin inputs, asynchronous |
| mode_i | input | 2*NUM_CH | Per-channel edge select |
| share_i | input | NUM_CH/2 | Pair join enables, one per even/odd pair |
| rd_i | input | NUM_CH | Per-channel read strobe, one clock wide |
| cap_o | output | 32*NUM_CH | Capture words, channel c at bits [32c+31:32c] |
| valid_o | output | NUM_CH | New capture present |
| ovr_o | output | NUM_CH | A capture was overwritten before being read |
| level_o | output | NUM_CH | Synchronised pin levels |

## Verification
The assertions assume that read strobes, edge selects and share enables are synchronous to the clock. They also assume that selects and share bits change only between measurements, never while an edge is pending. The bench changes configuration only early in a loop whose results it discards, and it drives strobes from the falling clock edge. The per-loop limit is stated for inputs whose high and low times each last at least one loop. The bench follows that limit except in the cases that probe the dropped second edge and the joined pair.

// File: rtl/hrcap_pkg.sv
package hrcap_pkg;

    localparam int unsigned DEF_FINE_W = 7;
    localparam int unsigned DEF_LOOP_W = 25;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
        logic h;
        case (sel)
            EDGE_RISE: h = rise;
            EDGE_FALL: h = fall;
            EDGE_ANY:  h = rise | fall;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/hrcap_timebase.sv
module hrcap_timebase #(
    parameter int unsigned FINE_W = hrcap_pkg::DEF_FINE_W,
    parameter int unsigned LOOP_W = hrcap_pkg::DEF_LOOP_W,
    localparam int unsigned STAMP_W = FINE_W + LOOP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [STAMP_W-1:0] stamp_o,
    output logic               tick_o
);

    typedef struct packed {
        logic [LOOP_W-1:0] loop;
        logic [FINE_W-1:0] fine;
    } tb_t;

    tb_t q, d;

    always_comb begin
        d = q;
        d.fine = q.fine + 1'b1;
        if (&q.fine) begin
            d.loop = q.loop + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stamp_o = q;
    assign tick_o  = &q.fine;

    assert_loop_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (stamp_o[FINE_W-1:0] == '0) &&
                   (stamp_o[STAMP_W-1:FINE_W] == $past(stamp_o[STAMP_W-1:FINE_W]) + 1'b1));

    assert_loop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(stamp_o[STAMP_W-1:FINE_W]));

endmodule

// File: rtl/hrcap_pinsync.sv
module hrcap_pinsync #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = pin_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.s2;
    assign rise_o  = q.s2 & ~q.s3;
    assign fall_o  = ~q.s2 & q.s3;

    assert_rise_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & ~$past(q.s1)) == '0);

    assert_fall_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o & $past(q.s1)) == '0);

endmodule

// File: rtl/hrcap_chan.sv
module hrcap_chan #(
    parameter int unsigned STAMP_W = 32,
    parameter int unsigned FINE_W  = hrcap_pkg::DEF_FINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [STAMP_W-1:0] stamp_i,
    input  logic               hit_i,
    input  logic               rd_i,
    output logic               take_o,
    output logic [STAMP_W-1:0] cap_o,
    output logic               valid_o,
    output logic               ovr_o
);

    typedef struct packed {
        logic               pend;
        logic [STAMP_W-1:0] pstamp;
        logic [STAMP_W-1:0] cap;
        logic               valid;
        logic               ovr;
    } ch_t;

    ch_t  q, d;
    logic publish;

    always_comb begin
        d       = q;
        take_o  = hit_i & ~q.pend;
        publish = tick_i & (q.pend | hit_i);
        if (take_o) begin
            d.pend   = 1'b1;
            d.pstamp = stamp_i;
        end
        if (rd_i) begin
            d.valid = 1'b0;
            d.ovr   = 1'b0;
        end
        if (tick_i) begin
            d.pend = 1'b0;
        end
        if (publish) begin
            d.cap   = q.pend ? q.pstamp : stamp_i;
            d.valid = 1'b1;
            d.ovr   = (q.ovr | q.valid) & ~rd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cap_o   = q.cap;
    assign valid_o = q.valid;
    assign ovr_o   = q.ovr;

    assert_publish_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(tick_i));

    assert_boundary_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i && !q.pend) |=> (cap_o[FINE_W-1:0] == '1));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !tick_i) |=> (!valid_o && !ovr_o));

    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (q.pend || hit_i) && valid_o && !rd_i) |=> ovr_o);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && (q.pend || hit_i)) |=> $stable(cap_o));

endmodule

// File: rtl/hr_edge_capture.sv
module hr_edge_capture #(
    parameter int unsigned NUM_CH = 32,
    parameter int unsigned FINE_W = hrcap_pkg::DEF_FINE_W,
    parameter int unsigned LOOP_W = hrcap_pkg::DEF_LOOP_W,
    localparam int unsigned STAMP_W = FINE_W + LOOP_W,
    localparam int unsigned NPAIR   = NUM_CH / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         pin_i,
    input  logic [2*NUM_CH-1:0]       mode_i,
    input  logic [NPAIR-1:0]          share_i,
    input  logic [NUM_CH-1:0]         rd_i,
    output logic [STAMP_W*NUM_CH-1:0] cap_o,
    output logic [NUM_CH-1:0]         valid_o,
    output logic [NUM_CH-1:0]         ovr_o,
    output logic [NUM_CH-1:0]         level_o
);
    import hrcap_pkg::*;

    logic [STAMP_W-1:0] stamp;
    logic               tick;
    logic [NUM_CH-1:0]  rise;
    logic [NUM_CH-1:0]  fall;
    logic [NPAIR-1:0]   even_take;
    logic [NPAIR-1:0]   odd_take;
    logic [NPAIR-1:0]   even_hit;
    logic [NPAIR-1:0]   odd_hit;

    hrcap_timebase #(.FINE_W(FINE_W), .LOOP_W(LOOP_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .stamp_o (stamp),
        .tick_o  (tick)
    );

    hrcap_pinsync #(.N(NUM_CH)) u_pinsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (level_o),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int unsigned EV = 2 * p;
        localparam int unsigned OD = 2 * p + 1;

        logic src_rise;
        logic src_fall;

        assign src_rise    = share_i[p] ? rise[EV] : rise[OD];
        assign src_fall    = share_i[p] ? fall[EV] : fall[OD];
        assign even_hit[p] = edge_hit(edge_sel_e'(mode_i[2*EV +: 2]), rise[EV], fall[EV]);
        assign odd_hit[p]  = edge_hit(edge_sel_e'(mode_i[2*OD +: 2]), src_rise, src_fall)
                             & ~(share_i[p] & even_take[p]);

        hrcap_chan #(.STAMP_W(STAMP_W), .FINE_W(FINE_W)) u_even (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .stamp_i (stamp),
            .hit_i   (even_hit[p]),
            .rd_i    (rd_i[EV]),
            .take_o  (even_take[p]),
            .cap_o   (cap_o[STAMP_W*EV +: STAMP_W]),
            .valid_o (valid_o[EV]),
            .ovr_o   (ovr_o[EV])
        );

        hrcap_chan #(.STAMP_W(STAMP_W), .FINE_W(FINE_W)) u_odd (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .stamp_i (stamp),
            .hit_i   (odd_hit[p]),
            .rd_i    (rd_i[OD]),
            .take_o  (odd_take[p]),
            .cap_o   (cap_o[STAMP_W*OD +: STAMP_W]),
            .valid_o (valid_o[OD]),
            .ovr_o   (ovr_o[OD])
        );

        assert_share_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
            share_i[p] |-> !(even_take[p] && odd_take[p]));

        assert_share_no_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (share_i[p] && !rise[EV] && !fall[EV]) |-> !odd_take[p]);
    end

endmodule

// File: tb/hr_edge_capture_bench.sv
module hr_edge_capture_bench;

    localparam int NCH = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    pin = '0;
    logic [2*NCH-1:0]  mode = '0;
    logic [NCH/2-1:0]  share = '0;
    logic [NCH-1:0]    rd = '0;
    logic [32*NCH-1:0] cap;
    logic [NCH-1:0]    valid;
    logic [NCH-1:0]    ovr;
    logic [NCH-1:0]    level;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    hr_edge_capture u_hr_edge_capture (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode), .share_i(share),
        .rd_i(rd), .cap_o(cap), .valid_o(valid), .ovr_o(ovr), .level_o(level)
    );

    // {ch[15:11], select[10:9], rising[8], fine[7:1], expect_hit[0]}
    localparam logic [15:0] VEC [9] = '{
        {5'd0,  2'd1, 1'b1, 7'd10,  1'b1},
        {5'd0,  2'd1, 1'b0, 7'd10,  1'b0},
        {5'd5,  2'd2, 1'b0, 7'd40,  1'b1},
        {5'd5,  2'd2, 1'b1, 7'd40,  1'b0},
        {5'd31, 2'd3, 1'b1, 7'd90,  1'b1},
        {5'd31, 2'd3, 1'b0, 7'd4,   1'b1},
        {5'd7,  2'd0, 1'b1, 7'd50,  1'b0},
        {5'd2,  2'd1, 1'b1, 7'd127, 1'b1},
        {5'd2,  2'd3, 1'b0, 7'd126, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_to(input int t);
        while (n < t) @(negedge clk);
    endtask

    function automatic int next_loop();
        return (n / 128 + 1) * 128;
    endfunction

    // drive pin so that the stamp fine offset becomes f within the loop at base
    task automatic drive(input int ch, input logic v, input int base, input int f);
        go_to(base + f - 2);
        pin[ch] = v;
    endtask

    task automatic read_pulse(input logic [NCH-1:0] m);
        rd = m;
        @(negedge clk);
        rd = '0;
    endtask

    function automatic logic [31:0] capw(input int ch);
        return cap[32*ch +: 32];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", valid, 0);
        chk("R1 ovr in reset", ovr, 0);
        chk("R1 cap ch0 in reset", capw(0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", valid, 0);
        chk("R1 cap ch31 after reset", capw(31), 0);

        // vector table: R2 R3 R4 R6
        foreach (VEC[i]) begin
            int ch, f, b0, b1;
            logic rise, hit;
            ch   = VEC[i][15:11];
            rise = VEC[i][8];
            f    = VEC[i][7:1];
            hit  = VEC[i][0];
            b0 = next_loop();
            b1 = b0 + 128;
            mode = '0;
            mode[2*ch +: 2] = VEC[i][10:9];
            go_to(b0 + 10);
            pin[ch] = ~rise;
            go_to(b1);
            read_pulse('1);
            drive(ch, rise, b1, f);
            go_to(b1 + 128);
            chk($sformatf("R3 vec%0d valid", i), valid[ch], hit);
            if (hit) chk($sformatf("R2 R4 R6 vec%0d stamp", i), capw(ch), b1 + f);
            chk($sformatf("R8 vec%0d no overrun", i), ovr[ch], 0);
            read_pulse('1);
        end

        // R5: second edge of a loop is dropped
        mode = '0;
        mode[2*3 +: 2] = 2'd3;
        b = next_loop();
        drive(3, ~pin[3], b, 20);
        drive(3, ~pin[3], b, 60);
        go_to(b + 128);
        chk("R5 first edge kept", capw(3), b + 20);

        // R8 overrun, then R7 collision and plain read
        drive(3, ~pin[3], b + 128, 30);
        go_to(b + 256);
        chk("R8 overrun set", ovr[3], 1);
        chk("R8 newer stamp", capw(3), b + 128 + 30);
        drive(3, ~pin[3], b + 256, 70);
        go_to(b + 383);
        rd[3] = 1'b1;
        go_to(b + 384);
        chk("R7 collision valid", valid[3], 1);
        chk("R7 collision ovr", ovr[3], 0);
        chk("R7 collision stamp", capw(3), b + 256 + 70);
        go_to(b + 385);
        rd[3] = 1'b0;
        chk("R7 read clears valid", valid[3], 0);

        // R11: a loop with no edge
        go_to(b + 512);
        chk("R11 valid stays clear", valid[3], 0);
        chk("R11 cap unchanged", capw(3), b + 256 + 70);

        // R9 R10: joined pair, rising on even, falling on odd
        mode = '0;
        mode[1:0] = 2'd1;
        mode[3:2] = 2'd2;
        share[0] = 1'b1;
        pin[0] = 1'b0;
        pin[1] = 1'b0;
        b = next_loop();
        go_to(b);
        read_pulse('1);
        drive(0, 1'b1, b, 20);
        drive(1, 1'b1, b, 30);
        drive(0, 1'b0, b, 60);
        go_to(b + 128);
        chk("R9 even rising stamp", capw(0), b + 20);
        chk("R9 odd falling from even pin", capw(1), b + 60);
        chk("R10 odd pin level", level[1], 1);
        read_pulse('1);

        // R9: both selects, odd gets second edge of the even pin
        mode[1:0] = 2'd3;
        mode[3:2] = 2'd3;
        b = next_loop();
        drive(0, 1'b1, b, 15);
        drive(1, 1'b0, b, 25);
        drive(0, 1'b0, b, 45);
        drive(0, 1'b1, b, 100);
        go_to(b + 128);
        chk("R9 even first edge", capw(0), b + 15);
        chk("R9 odd second edge", capw(1), b + 45);
        chk("R10 odd level low", level[1], 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule